// File: doc/BRIEF.md
# Shared Bus Interconnect with Default Slave

This block joins a set of bus masters to a set of memory-mapped slaves through one shared path. A master raises its request line, and in the same cycle the interconnect answers with a grant. If the granted master also presents a valid transaction, carrying address, write flag and write data together, the interconnect accepts it in that cycle. It decodes the address into a one-hot slave select and drives the transaction onto the slave side.

Once a transaction is accepted, the granted master owns the bus until the selected slave answers, however many cycles that takes. The answer is then steered back to the owning master, and the bus is free again from the next cycle. An address outside every mapped region goes to a built-in default slave, which always answers one cycle later with an error. Every accepted transaction therefore gets exactly one response.

Top module: `shared_bus`

## Requirements
- R1: During and right after reset no master is granted, no slave valid is driven and no master sees a response valid.
- R2: When the bus is free, the grant goes in the same cycle to the requesting master with the lowest index, and only to that master.
- R3: From the cycle a transaction is accepted until the cycle its response arrives (inclusive), the grant stays with the owning master and no other requester is granted. In the following cycle the bus is free again.
- R4: A valid transaction from a master granted on a free bus is forwarded in the same cycle: exactly one bit of `s_valid` is set, and `s_addr`, `s_wdata` and `s_write` carry that master's fields.
- R5: Address bits [15:12] form a region number k. If k is less than the slave count (0 or 1 at the defaults), slave k is selected. Any other value selects the default slave, and `s_valid` stays low.
- R6: A transaction sent to the default slave is answered one cycle after acceptance, with `m_rerr` = 1 and `m_rdata` = 0.
- R7: A response from the selected slave is accepted after any delay of one cycle or more. It raises `m_rvalid` only for the owning master, with that slave's error flag and read data.
- R8: Responses are ignored while the bus is free, and from any slave other than the selected one while the bus is owned. Neither case raises `m_rvalid`, and neither releases ownership.
- R9: A granted master with `m_valid` low gets its grant, but nothing is forwarded, no response follows and the bus stays free for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | NM | Bus request, one per master |
| m_gnt | output | NM | Bus grant, one per master |
| m_valid | input | NM | Transaction present, one per master |
| m_write | input | NM | Write flag, one per master |
| m_addr | input | NM*16 | Transaction address, master i at bits [16i+15:16i] |
| m_wdata | input | NM*32 | Write data, master i at bits [32i+31:32i] |
| m_rvalid | output | NM | Response valid to the owning master |
| m_rerr | output | 1 | Response error flag, shared |
| m_rdata | output | 32 | Response read data, shared |
| s_valid | output | NS | Transaction select, one per slave |
| s_write | output | 1 | Forwarded write flag |
| s_addr | output | 16 | Forwarded address |
| s_wdata | output | 32 | Forwarded write data |
| s_rvalid | input | NS | Response valid, one per slave |
| s_rerr | input | NS | Response error, one per slave |
| s_rdata | input | NS*32 | Read data, slave j at bits [32j+31:32j] |

## Verification
The only state inside this block is the ownership flag, the owning master and the latched target. A wrong owning master shows up at once as a grant on the wrong line. A wrong latched target shows up on the response cycle: a response is dropped, or a response from the wrong slave is passed through. A stuck or lost busy flag shows up one cycle after a response, when the bus is either not released to a waiting master or released while a slave is still working. The bench therefore checks the grant on every cycle of a pending transaction and again on the cycle after the response.

// File: rtl/bus_pkg.sv
package bus_pkg;

    localparam int AW         = 16;
    localparam int DW         = 32;
    localparam int REGION_LSB = 12;
    localparam int REGION_W   = 4;

    typedef struct packed {
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } txn_t;

    typedef struct packed {
        logic          err;
        logic [DW-1:0] rdata;
    } rsp_t;

    function automatic logic [REGION_W-1:0] region_of(input logic [AW-1:0] a);
        return a[REGION_LSB +: REGION_W];
    endfunction

endpackage

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
    parameter int NM = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NM-1:0] req,
    input  logic          start,
    input  logic          done,
    output logic [NM-1:0] gnt,
    output logic          busy
);
    logic [NM-1:0] pick;
    logic [NM-1:0] own_q;
    logic          busy_q;

    // Fixed priority: lowest index wins.
    always_comb begin
        pick = '0;
        for (int i = NM - 1; i >= 0; i--) begin
            if (req[i]) pick = NM'(1) << i;
        end
    end

    assign gnt  = busy_q ? own_q : pick;
    assign busy = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            own_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            own_q  <= pick;
        end else if (done) begin
            busy_q <= 1'b0;
            own_q  <= '0;
        end
    end

    assert_prio_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && req[0]) |-> gnt[0]);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (gnt == $past(gnt)));

    assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

endmodule

// File: rtl/bus_decoder.sv
module bus_decoder
    import bus_pkg::*;
#(
    parameter int NS = 2
) (
    input  logic [AW-1:0] addr,
    output logic [NS:0]   sel
);
    logic [REGION_W-1:0] region;
    logic [NS-1:0]       hit;

    assign region = region_of(addr);

    for (genvar k = 0; k < NS; k++) begin : g_hit
        assign hit[k] = (region == REGION_W'(k));
    end

    assign sel = {~(|hit), hit};

endmodule

// File: rtl/bus_default_slave.sv
module bus_default_slave
    import bus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    output logic rvalid,
    output rsp_t rsp
);
    always_ff @(posedge clk) begin
        if (rst) rvalid <= 1'b0;
        else     rvalid <= sel;
    end

    assign rsp = '{err: 1'b1, rdata: '0};

    assert_dflt_next_R6: assert property (@(posedge clk) disable iff (rst)
        sel |=> rvalid);

    assert_dflt_cause_R6: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $past(sel));

endmodule

// File: rtl/shared_bus.sv
module shared_bus
    import bus_pkg::*;
#(
    parameter int NM = 2,
    parameter int NS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NM-1:0]    m_req,
    output logic [NM-1:0]    m_gnt,
    input  logic [NM-1:0]    m_valid,
    input  logic [NM-1:0]    m_write,
    input  logic [NM*AW-1:0] m_addr,
    input  logic [NM*DW-1:0] m_wdata,
    output logic [NM-1:0]    m_rvalid,
    output logic             m_rerr,
    output logic [DW-1:0]    m_rdata,
    output logic [NS-1:0]    s_valid,
    output logic             s_write,
    output logic [AW-1:0]    s_addr,
    output logic [DW-1:0]    s_wdata,
    input  logic [NS-1:0]    s_rvalid,
    input  logic [NS-1:0]    s_rerr,
    input  logic [NS*DW-1:0] s_rdata
);
    logic [NM-1:0] gnt;
    logic          busy, start, done;
    txn_t          g_txn;
    logic          g_valid;
    logic [NS:0]   dec_sel;
    logic [NS:0]   tgt_q;
    logic [NS:0]   rv_all;
    logic          dflt_rvalid;
    rsp_t          dflt_rsp;
    rsp_t          r_sel;

    bus_arbiter #(.NM(NM)) u_arb (
        .clk(clk), .rst(rst), .req(m_req), .start(start),
        .done(done), .gnt(gnt), .busy(busy)
    );

    // Mux the granted master's transaction (grant is one-hot).
    always_comb begin
        g_txn   = '0;
        g_valid = 1'b0;
        for (int i = 0; i < NM; i++) begin
            if (gnt[i]) begin
                g_txn   = '{write: m_write[i], addr: m_addr[i*AW +: AW],
                            wdata: m_wdata[i*DW +: DW]};
                g_valid = m_valid[i];
            end
        end
    end

    assign start = !busy && g_valid;

    bus_decoder #(.NS(NS)) u_dec (.addr(g_txn.addr), .sel(dec_sel));

    bus_default_slave u_dflt (
        .clk(clk), .rst(rst), .sel(start && dec_sel[NS]),
        .rvalid(dflt_rvalid), .rsp(dflt_rsp)
    );

    assign s_valid = start ? dec_sel[NS-1:0] : '0;
    assign s_write = g_txn.write;
    assign s_addr  = g_txn.addr;
    assign s_wdata = g_txn.wdata;

    always_ff @(posedge clk) begin
        if (rst)        tgt_q <= '0;
        else if (start) tgt_q <= dec_sel;
        else if (done)  tgt_q <= '0;
    end

    assign rv_all = {dflt_rvalid, s_rvalid};
    assign done   = busy && |(tgt_q & rv_all);

    always_comb begin
        r_sel = '0;
        for (int j = 0; j < NS; j++) begin
            if (tgt_q[j]) r_sel = '{err: s_rerr[j], rdata: s_rdata[j*DW +: DW]};
        end
        if (tgt_q[NS]) r_sel = dflt_rsp;
    end

    assign m_gnt    = gnt;
    assign m_rvalid = done ? gnt : '0;
    assign m_rerr   = done & r_sel.err;
    assign m_rdata  = done ? r_sel.rdata : '0;

    assert_svalid_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_valid));

    assert_svalid_granted_R4: assert property (@(posedge clk) disable iff (rst)
        (s_valid != '0) |-> ((m_gnt & m_valid) != '0));

    assert_rsp_release_R7: assert property (@(posedge clk) disable iff (rst)
        (m_rvalid != '0) |=> !busy);

    assert_rsp_to_owner_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_rvalid) && ((m_rvalid & ~m_gnt) == '0));

    assert_idle_no_fwd_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && (m_gnt & m_valid) == '0) |-> (s_valid == '0));

    assert_free_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && s_rvalid != '0) |-> (m_rvalid == '0));

endmodule

// File: tb/tb_shared_bus.sv
`timescale 1ns/1ps
module tb_shared_bus;
    localparam int NM = 2;
    localparam int NS = 2;

    logic            clk = 1'b0;
    logic            rst;
    logic [NM-1:0]   m_req, m_gnt, m_valid, m_write, m_rvalid;
    logic [NM*16-1:0] m_addr;
    logic [NM*32-1:0] m_wdata;
    logic            m_rerr;
    logic [31:0]     m_rdata;
    logic [NS-1:0]   s_valid, s_rvalid, s_rerr;
    logic            s_write;
    logic [15:0]     s_addr;
    logic [31:0]     s_wdata;
    logic [NS*32-1:0] s_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    shared_bus #(.NM(NM), .NS(NS)) dut (
        .clk(clk), .rst(rst), .m_req(m_req), .m_gnt(m_gnt), .m_valid(m_valid),
        .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata), .m_rvalid(m_rvalid),
        .m_rerr(m_rerr), .m_rdata(m_rdata), .s_valid(s_valid), .s_write(s_write),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_rvalid(s_rvalid), .s_rerr(s_rerr),
        .s_rdata(s_rdata)
    );

    typedef struct packed {
        logic        m;
        logic        wr;
        logic [15:0] addr;
        logic [31:0] wd;
        logic [2:0]  lat;
        logic [31:0] rd;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, 16'h0004, 32'hA5A5_0001, 3'd1, 32'h1111_1111},
        '{1'b1, 1'b0, 16'h1ABC, 32'h0000_0000, 3'd2, 32'hCAFE_F00D},
        '{1'b0, 1'b0, 16'h2000, 32'h0000_0000, 3'd1, 32'h0000_0000},
        '{1'b1, 1'b1, 16'hF00F, 32'h5A5A_7777, 3'd1, 32'h0000_0000},
        '{1'b0, 1'b0, 16'h1FFF, 32'h0000_0000, 3'd3, 32'h0BAD_BEEF},
        '{1'b1, 1'b1, 16'h0FFF, 32'h1357_9BDF, 3'd1, 32'h1234_5678}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        m_req = '0; m_valid = '0; m_write = '0; m_addr = '0; m_wdata = '0;
        s_rvalid = '0; s_rerr = '0; s_rdata = '0;
    endtask

    task automatic drive_master(input int m, input logic v, input logic wr,
                                input logic [15:0] a, input logic [31:0] d);
        m_req[m] = 1'b1; m_valid[m] = v; m_write[m] = wr;
        m_addr[m*16 +: 16] = a; m_wdata[m*32 +: 32] = d;
    endtask

    task automatic respond(input int s, input logic e, input logic [31:0] d);
        s_rvalid = '0; s_rvalid[s] = 1'b1; s_rerr[s] = e; s_rdata[s*32 +: 32] = d;
    endtask

    task automatic run_vec(input vec_t v);
        int  m    = int'(v.m);
        int  sidx = int'(v.addr[15:12]);
        bit  dflt = (sidx >= NS);
        @(negedge clk);
        drive_master(m, 1'b1, v.wr, v.addr, v.wd);
        #1;
        check("R2 grant", 64'(m_gnt), 64'(1 << m));
        check("R5 select", 64'(s_valid), dflt ? 64'd0 : 64'(1 << sidx));
        if (!dflt) begin
            check("R4 addr", 64'(s_addr), 64'(v.addr));
            check("R4 wdata", 64'(s_wdata), 64'(v.wd));
            check("R4 write", 64'(s_write), 64'(v.wr));
        end
        @(negedge clk);
        m_req[m] = 1'b0; m_valid[m] = 1'b0;
        #1;
        if (dflt) begin
            check("R6 rvalid", 64'(m_rvalid), 64'(1 << m));
            check("R6 rerr", 64'(m_rerr), 64'd1);
            check("R6 rdata", 64'(m_rdata), 64'd0);
        end else begin
            for (int k = 1; k < int'(v.lat); k++) begin
                check("R3 hold", 64'(m_gnt), 64'(1 << m));
                check("R7 early", 64'(m_rvalid), 64'd0);
                @(negedge clk);
                #1;
            end
            respond(sidx, 1'b0, v.rd);
            #1;
            check("R7 rvalid", 64'(m_rvalid), 64'(1 << m));
            check("R7 rdata", 64'(m_rdata), 64'(v.rd));
            check("R7 rerr", 64'(m_rerr), 64'd0);
        end
        @(negedge clk);
        s_rvalid = '0;
        #1;
        check("R3 free", 64'(m_gnt), 64'd0);
        check("R7 pulse", 64'(m_rvalid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 gnt in reset", 64'(m_gnt), 64'd0);
        check("R1 s_valid in reset", 64'(s_valid), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 gnt after reset", 64'(m_gnt), 64'd0);
        check("R1 rvalid after reset", 64'(m_rvalid), 64'd0);

        // Table of transactions
        foreach (VECS[i]) run_vec(VECS[i]);

        // R2 + R3: both masters request, lowest index wins, other waits
        @(negedge clk);
        drive_master(0, 1'b1, 1'b0, 16'h0000, 32'h0);
        drive_master(1, 1'b1, 1'b1, 16'h1000, 32'hDEAD_0001);
        #1;
        check("R2 prio grant", 64'(m_gnt), 64'b01);
        check("R2 prio addr", 64'(s_addr), 64'h0000);
        check("R4 prio select", 64'(s_valid), 64'b01);
        @(negedge clk);
        m_req[0] = 1'b0; m_valid[0] = 1'b0;
        #1;
        check("R3 hold vs waiter", 64'(m_gnt), 64'b01);
        check("R3 no forward while owned", 64'(s_valid), 64'd0);
        respond(0, 1'b1, 32'h0000_00EE);
        #1;
        check("R7 err passthrough", 64'(m_rerr), 64'd1);
        check("R7 rvalid owner", 64'(m_rvalid), 64'b01);
        @(negedge clk);
        s_rvalid = '0;
        #1;
        check("R3 handover", 64'(m_gnt), 64'b10);
        check("R4 handover select", 64'(s_valid), 64'b10);
        check("R4 handover wdata", 64'(s_wdata), 64'hDEAD_0001);
        @(negedge clk);
        clear_inputs();
        // R8: wrong slave answers while owned by master 1 targeting slave 1
        respond(0, 1'b0, 32'h7);
        #1;
        check("R8 wrong slave", 64'(m_rvalid), 64'd0);
        check("R8 still owned", 64'(m_gnt), 64'b10);
        @(negedge clk);
        respond(1, 1'b0, 32'h99);
        #1;
        check("R7 right slave", 64'(m_rvalid), 64'b10);
        check("R7 right data", 64'(m_rdata), 64'h99);
        @(negedge clk);
        clear_inputs();
        // R8: response while bus is free
        respond(0, 1'b0, 32'h5);
        #1;
        check("R8 free response", 64'(m_rvalid), 64'd0);
        @(negedge clk);
        clear_inputs();
        #1;
        check("R8 still free", 64'(m_gnt), 64'd0);

        // R9: idle transaction
        @(negedge clk);
        drive_master(0, 1'b0, 1'b1, 16'h0010, 32'h1);
        #1;
        check("R9 idle grant", 64'(m_gnt), 64'b01);
        check("R9 idle no forward", 64'(s_valid), 64'd0);
        @(negedge clk);
        clear_inputs();
        drive_master(1, 1'b1, 1'b0, 16'h0020, 32'h0);
        #1;
        check("R9 bus stays free", 64'(m_gnt), 64'b10);
        check("R9 next forward", 64'(s_valid), 64'b01);
        check("R9 no response", 64'(m_rvalid), 64'd0);
        @(negedge clk);
        clear_inputs();
        respond(0, 1'b0, 32'h42);
        #1;
        check("R7 cleanup", 64'(m_rvalid), 64'b10);
        @(negedge clk);
        clear_inputs();
        repeat (2) @(negedge clk);

        done_flag = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule